// File: doc/BRIEF.md
# Snooping Cache Line Coherence State Controller

This block keeps the four-state coherence state of every line slot in one private cache of a multi-core system whose caches watch a shared bus. Each cycle it accepts at most one local operation (read, write or eviction) and at most one snooped operation issued on the bus by another core (read, read-for-ownership or invalidate). For each, it updates the state of the addressed slot and produces the bus actions this cache owes. Tag matching happens outside, so requests name a slot index. A line counts as present when its state is anything other than Invalid. The shared indication returned with a bus read arrives together with the local read request.

A snooped read that finds a dirty line is answered by this cache: it supplies the data, writes the line back and keeps a Shared copy. A local write to a Shared copy broadcasts an invalidate. When a snoop and a local operation name the same slot in the same cycle, the snoop is applied first and the local operation then acts on the resulting state. With the default registered output variant, every action appears on the outputs one clock after its request. A query port reads any slot's state combinationally.

Top module: `mesi_line_ctrl`

## Requirements
- R1: State codes are Invalid=00, Shared=01, Exclusive=10, Modified=11. After reset every slot reads Invalid on the query port.
- R2: A local read (lcl_op=1) to an Invalid slot issues bus command READ (1) with lcl_hit=0. The slot becomes Exclusive when lcl_shared=0 and Shared when lcl_shared=1.
- R3: A local read or write to a slot that is not Invalid reports lcl_hit=1. A read hit changes no state and issues no bus command (NONE=0), and a write to a Modified slot likewise issues no bus command.
- R4: A local write (lcl_op=2) to an Exclusive slot moves it to Modified with bus command NONE.
- R5: A local write to a Shared slot issues bus command INV (3) and moves the slot to Modified.
- R6: A local write to an Invalid slot issues bus command RFO (2), reports lcl_hit=0 and installs the slot in Modified.
- R7: A snooped read (snp_op=1) moves an Exclusive slot to Shared, leaves Shared and Invalid slots unchanged, and does not assert snp_supply.
- R8: A snooped read to a Modified slot asserts both snp_supply and snp_wb with snp_resp_slot equal to the snooped slot, and the slot moves to Shared.
- R9: A snooped read-for-ownership (snp_op=2) or invalidate (snp_op=3) moves the slot to Invalid. A read-for-ownership to a Modified slot asserts snp_supply without snp_wb.
- R10: A local eviction (lcl_op=3) of a Modified slot issues bus command WB (4). Evicting a clean slot issues NONE. Either way the slot becomes Invalid.
- R11: When a snoop and a local operation target the same slot in one cycle, the local operation acts on the post-snoop state. Operations on different slots in the same cycle both take effect.
- R12: With OUT_REG=1, bus_cmd, bus_slot, lcl_hit, snp_supply, snp_wb and snp_resp_slot reflect the operation presented one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_op | input | 2 | Local operation: 0 none, 1 read, 2 write, 3 evict |
| lcl_slot | input | SLOT_W | Slot addressed by the local operation |
| lcl_shared | input | 1 | Another cache holds the line; valid with a local read |
| snp_op | input | 2 | Snooped operation: 0 none, 1 read, 2 read-for-ownership, 3 invalidate |
| snp_slot | input | SLOT_W | Slot addressed by the snoop |
| qry_slot | input | SLOT_W | Slot whose state is shown on qry_state |
| qry_state | output | 2 | Current state of qry_slot |
| bus_cmd | output | 3 | Bus command: 0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 writeback |
| bus_slot | output | SLOT_W | Slot that bus_cmd concerns |
| lcl_hit | output | 1 | Local read or write found the line present |
| snp_supply | output | 1 | This cache provides the line data to the snooping requester |
| snp_wb | output | 1 | Snoop-triggered writeback of the line to memory |
| snp_resp_slot | output | SLOT_W | Slot that snp_supply and snp_wb concern |

## Verification
The bench builds the block with NUM_LINES=8 and OUT_REG=1. Eight slots are enough to keep a different line in each of the four states at once, and to run same-cycle snoop-plus-local pairs on one slot and on two different slots. The registered variant places each action exactly one edge after its request, so a scoreboard can match every response to its operation, including the dirty-line supply with writeback and the eviction writeback.

// File: rtl/mesi_coh_pkg.sv
package mesi_coh_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_S = 2'b01,
      ST_E = 2'b10,
      ST_M = 2'b11
   } line_st_t;

   typedef enum logic [1:0] {
      L_NOP   = 2'd0,
      L_RD    = 2'd1,
      L_WR    = 2'd2,
      L_EVICT = 2'd3
   } lcl_op_t;

   typedef enum logic [1:0] {
      S_NOP = 2'd0,
      S_RD  = 2'd1,
      S_RFO = 2'd2,
      S_INV = 2'd3
   } snp_op_t;

   typedef enum logic [2:0] {
      B_NONE = 3'd0,
      B_READ = 3'd1,
      B_RFO  = 3'd2,
      B_INV  = 3'd3,
      B_WB   = 3'd4
   } bus_cmd_t;
endpackage

// File: rtl/mesi_snoop_xfer.sv
module mesi_snoop_xfer
   import mesi_coh_pkg::*;
(
   input  line_st_t cur,
   input  snp_op_t  op,
   output line_st_t nxt,
   output logic     supply,
   output logic     wb
);
   always_comb begin
      nxt    = cur;
      supply = 1'b0;
      wb     = 1'b0;
      case (op)
         S_RD: begin
            if (cur == ST_M) begin
               supply = 1'b1;   // R8: dirty copy answers the read
               wb     = 1'b1;
               nxt    = ST_S;
            end else if (cur == ST_E) begin
               nxt = ST_S;      // R7
            end
         end
         S_RFO: begin
            supply = (cur == ST_M);  // R9
            nxt    = ST_I;
         end
         S_INV:   nxt = ST_I;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/mesi_local_xfer.sv
module mesi_local_xfer
   import mesi_coh_pkg::*;
(
   input  line_st_t cur,
   input  lcl_op_t  op,
   input  logic     shared_in,
   output line_st_t nxt,
   output bus_cmd_t cmd,
   output logic     hit
);
   always_comb begin
      nxt = cur;
      cmd = B_NONE;
      hit = ((op == L_RD) || (op == L_WR)) && (cur != ST_I);
      case (op)
         L_RD: begin
            if (cur == ST_I) begin
               cmd = B_READ;                       // R2
               nxt = shared_in ? ST_S : ST_E;
            end
         end
         L_WR: begin
            nxt = ST_M;
            if (cur == ST_I)      cmd = B_RFO;      // R6
            else if (cur == ST_S) cmd = B_INV;      // R5
         end
         L_EVICT: begin
            nxt = ST_I;
            if (cur == ST_M) cmd = B_WB;            // R10
         end
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/mesi_state_file.sv
module mesi_state_file
   import mesi_coh_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int SLOT_W    = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lcl_we,
   input  logic [SLOT_W-1:0] lcl_slot,
   input  line_st_t          lcl_nxt,
   input  logic              snp_we,
   input  logic [SLOT_W-1:0] snp_slot,
   input  line_st_t          snp_nxt,
   output line_st_t          st_all [NUM_LINES]
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_slot
      line_st_t st_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st_r <= ST_I;
         else if (lcl_we && (lcl_slot == SLOT_W'(i)))
            st_r <= lcl_nxt;   // local result already includes a same-slot snoop
         else if (snp_we && (snp_slot == SLOT_W'(i)))
            st_r <= snp_nxt;
      end
      assign st_all[i] = st_r;
   end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_coh_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int OUT_REG   = 1,
   localparam int SLOT_W   = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        lcl_op,
   input  logic [SLOT_W-1:0] lcl_slot,
   input  logic              lcl_shared,
   input  logic [1:0]        snp_op,
   input  logic [SLOT_W-1:0] snp_slot,
   input  logic [SLOT_W-1:0] qry_slot,
   output logic [1:0]        qry_state,
   output logic [2:0]        bus_cmd,
   output logic [SLOT_W-1:0] bus_slot,
   output logic              lcl_hit,
   output logic              snp_supply,
   output logic              snp_wb,
   output logic [SLOT_W-1:0] snp_resp_slot
);
   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("OUT_REG must be 0 or 1");
   end

   lcl_op_t  l_op;
   snp_op_t  s_op;
   line_st_t st_all [NUM_LINES];
   line_st_t s_cur, s_nxt, l_cur, l_nxt;
   logic     s_sup, s_wb, l_hit, s_act, l_act;
   bus_cmd_t l_cmd;

   assign l_op  = lcl_op_t'(lcl_op);
   assign s_op  = snp_op_t'(snp_op);
   assign s_act = (s_op != S_NOP);
   assign l_act = (l_op != L_NOP);

   assign s_cur = st_all[snp_slot];
   // R11: a same-slot snoop is applied before the local operation
   assign l_cur = (s_act && (snp_slot == lcl_slot)) ? s_nxt : st_all[lcl_slot];

   mesi_snoop_xfer u_snp (
      .cur(s_cur), .op(s_op), .nxt(s_nxt), .supply(s_sup), .wb(s_wb)
   );

   mesi_local_xfer u_lcl (
      .cur(l_cur), .op(l_op), .shared_in(lcl_shared),
      .nxt(l_nxt), .cmd(l_cmd), .hit(l_hit)
   );

   mesi_state_file #(.NUM_LINES(NUM_LINES), .SLOT_W(SLOT_W)) u_sf (
      .clk(clk), .rst_n(rst_n),
      .lcl_we(l_act), .lcl_slot(lcl_slot), .lcl_nxt(l_nxt),
      .snp_we(s_act), .snp_slot(snp_slot), .snp_nxt(s_nxt),
      .st_all(st_all)
   );

   assign qry_state = st_all[qry_slot];

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bus_cmd       <= '0;
            bus_slot      <= '0;
            lcl_hit       <= 1'b0;
            snp_supply    <= 1'b0;
            snp_wb        <= 1'b0;
            snp_resp_slot <= '0;
         end else begin
            bus_cmd       <= l_cmd;
            bus_slot      <= lcl_slot;
            lcl_hit       <= l_hit;
            snp_supply    <= s_sup;
            snp_wb        <= s_wb;
            snp_resp_slot <= snp_slot;
         end
      end

      p_supply_from_mod_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ((s_op == S_RD || s_op == S_RFO) && st_all[snp_slot] == ST_M) |=> snp_supply);

      p_evict_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (l_op == L_EVICT && st_all[lcl_slot] == ST_M
          && !(s_act && snp_slot == lcl_slot)) |=> (bus_cmd == 3'd4));

      p_miss_not_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_cmd == 3'd1) |-> !lcl_hit);
   end else begin : g_comb
      assign bus_cmd       = l_cmd;
      assign bus_slot      = lcl_slot;
      assign lcl_hit       = l_hit;
      assign snp_supply    = s_sup;
      assign snp_wb        = s_wb;
      assign snp_resp_slot = snp_slot;
   end

   p_wr_to_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (l_op == L_WR) |=> (st_all[$past(lcl_slot)] == ST_M));

   p_inv_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_op == S_INV && !(l_act && lcl_slot == snp_slot))
      |=> (st_all[$past(snp_slot)] == ST_I));

   p_evict_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (l_op == L_EVICT) |=> (st_all[$past(lcl_slot)] == ST_I));
endmodule

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb;
   localparam int NL = 8;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    lcl_op = '0;
   logic [SW-1:0] lcl_slot = '0;
   logic          lcl_shared = 1'b0;
   logic [1:0]    snp_op = '0;
   logic [SW-1:0] snp_slot = '0;
   logic [SW-1:0] qry_slot = '0;
   logic [1:0]    qry_state;
   logic [2:0]    bus_cmd;
   logic [SW-1:0] bus_slot;
   logic          lcl_hit, snp_supply, snp_wb;
   logic [SW-1:0] snp_resp_slot;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [2:0]    cmd;
      logic [SW-1:0] bslot;
      logic          hit;
      logic          sup;
      logic          wb;
      logic [SW-1:0] sslot;
      int            req;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   mesi_line_ctrl #(.NUM_LINES(NL), .OUT_REG(1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .lcl_op(lcl_op), .lcl_slot(lcl_slot), .lcl_shared(lcl_shared),
      .snp_op(snp_op), .snp_slot(snp_slot),
      .qry_slot(qry_slot), .qry_state(qry_state),
      .bus_cmd(bus_cmd), .bus_slot(bus_slot), .lcl_hit(lcl_hit),
      .snp_supply(snp_supply), .snp_wb(snp_wb), .snp_resp_slot(snp_resp_slot)
   );

   // Monitor: one expected item per driven cycle, compared after the edge (R12)
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (bus_cmd !== e.cmd || (e.cmd != 0 && bus_slot !== e.bslot) ||
                lcl_hit !== e.hit || snp_supply !== e.sup || snp_wb !== e.wb ||
                ((e.sup || e.wb) && snp_resp_slot !== e.sslot)) begin
               fails++;
               $display("FAIL R%0d: cmd=%0d slot=%0d hit=%0b sup=%0b wb=%0b rslot=%0d expected cmd=%0d slot=%0d hit=%0b sup=%0b wb=%0b rslot=%0d",
                        e.req, bus_cmd, bus_slot, lcl_hit, snp_supply, snp_wb, snp_resp_slot,
                        e.cmd, e.bslot, e.hit, e.sup, e.wb, e.sslot);
            end
         end
      end
   end

   task automatic step(input logic [1:0] lop, input logic [SW-1:0] ls, input logic sh,
                       input logic [1:0] sop, input logic [SW-1:0] ss,
                       input logic [2:0] ecmd, input logic ehit,
                       input logic esup, input logic ewb, input int req);
      exp_t e;
      @(negedge clk);
      lcl_op = lop; lcl_slot = ls; lcl_shared = sh;
      snp_op = sop; snp_slot = ss;
      e.cmd = ecmd; e.bslot = ls; e.hit = ehit; e.sup = esup; e.wb = ewb;
      e.sslot = ss; e.req = req;
      q.push_back(e);
      @(posedge clk);
      #1;
      lcl_op = 2'd0; snp_op = 2'd0; lcl_shared = 1'b0;
   endtask

   task automatic chk_state(input logic [SW-1:0] s, input logic [1:0] exp_st, input int req);
      qry_slot = s;
      #1;
      checks++;
      if (qry_state !== exp_st) begin
         fails++;
         $display("FAIL R%0d: slot %0d state=%0d expected %0d", req, s, qry_state, exp_st);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NL; i++) chk_state(SW'(i), 2'b00, 1);          // R1

      step(2'd1, 3'd1, 1'b0, 2'd0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 2);     // R2 exclusive fill
      chk_state(3'd1, 2'b10, 2);
      step(2'd1, 3'd2, 1'b1, 2'd0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 2);     // R2 shared fill
      chk_state(3'd2, 2'b01, 2);
      step(2'd1, 3'd1, 1'b0, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 3);     // R3 read hit
      chk_state(3'd1, 2'b10, 3);
      step(2'd0, 3'd0, 1'b0, 2'd1, 3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 7);     // R7 E->S
      chk_state(3'd1, 2'b01, 7);
      step(2'd0, 3'd0, 1'b0, 2'd1, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0, 7);     // R7 S stays
      chk_state(3'd2, 2'b01, 7);
      step(2'd2, 3'd2, 1'b0, 2'd0, 3'd0, 3'd3, 1'b1, 1'b0, 1'b0, 5);     // R5 upgrade
      chk_state(3'd2, 2'b11, 5);
      step(2'd2, 3'd3, 1'b0, 2'd0, 3'd0, 3'd2, 1'b0, 1'b0, 1'b0, 6);     // R6 write miss
      chk_state(3'd3, 2'b11, 6);
      step(2'd1, 3'd4, 1'b0, 2'd0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 2);
      step(2'd2, 3'd4, 1'b0, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 4);     // R4 silent E->M
      chk_state(3'd4, 2'b11, 4);
      step(2'd0, 3'd0, 1'b0, 2'd1, 3'd3, 3'd0, 1'b0, 1'b1, 1'b1, 8);     // R8 supply + wb
      chk_state(3'd3, 2'b01, 8);
      step(2'd0, 3'd0, 1'b0, 2'd2, 3'd2, 3'd0, 1'b0, 1'b1, 1'b0, 9);     // R9 RFO on M
      chk_state(3'd2, 2'b00, 9);
      step(2'd0, 3'd0, 1'b0, 2'd3, 3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 9);     // R9 invalidate
      chk_state(3'd1, 2'b00, 9);
      step(2'd3, 3'd4, 1'b0, 2'd0, 3'd0, 3'd4, 1'b0, 1'b0, 1'b0, 10);    // R10 dirty evict
      chk_state(3'd4, 2'b00, 10);
      step(2'd1, 3'd5, 1'b0, 2'd0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 2);
      step(2'd3, 3'd5, 1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 10);    // R10 clean evict
      chk_state(3'd5, 2'b00, 10);
      step(2'd1, 3'd6, 1'b0, 2'd0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 2);
      step(2'd2, 3'd6, 1'b0, 2'd1, 3'd6, 3'd3, 1'b1, 1'b0, 1'b0, 11);    // R11 snoop E->S then write
      chk_state(3'd6, 2'b11, 11);
      step(2'd1, 3'd6, 1'b1, 2'd3, 3'd6, 3'd1, 1'b0, 1'b0, 1'b0, 11);    // R11 invalidate then read miss
      chk_state(3'd6, 2'b01, 11);
      step(2'd2, 3'd7, 1'b0, 2'd1, 3'd6, 3'd2, 1'b0, 1'b0, 1'b0, 11);    // R11 different slots
      chk_state(3'd7, 2'b11, 11);
      chk_state(3'd6, 2'b01, 11);
      step(2'd2, 3'd7, 1'b0, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 3);     // R3 write hit on M
      chk_state(3'd7, 2'b11, 3);
      step(2'd1, 3'd0, 1'b0, 2'd0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 2);
      step(2'd0, 3'd0, 1'b0, 2'd2, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 9);     // R9 RFO on E
      chk_state(3'd0, 2'b00, 9);
      step(2'd0, 3'd0, 1'b0, 2'd1, 3'd5, 3'd0, 1'b0, 1'b0, 1'b0, 7);     // R7 snoop read on I
      chk_state(3'd5, 2'b00, 7);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule